// File: doc/BRIEF.md
# Grouped Interrupt Controller with Clear-on-Read

This block gathers single-cycle event pulses from three groups of eight sources each: packet handling (group 0), chip condition (group 1) and modem (group 2). Each event that is enabled when it arrives is caught in a pending latch. An active-low interrupt pin is pulled low while any pending bit is still enabled. The pin is released once the host has read and cleared the pending bits.

Enabling works on two levels. A three-bit group enable and an eight-bit event enable per group must both be set for an event to latch and to drive the pin. The host reads in one of two ways. A full read returns every group and clears all of them. A group read returns one group and clears only that group. Each read also returns the live condition of every source in the selected groups, whatever the enables hold. A snoop bus shows the pending bits at all times, for a fast readback path. Looking at it never clears anything and never releases the pin.

Top module: `irq_group_ctrl`

## Requirements
- R1: After reset, irq_n is 1, snp_pend is all zero, rd_valid is 0, and every group enable and event enable is 0.
- R2: An evt_i pulse on bit 8g+b sets snp_pend bit 8g+b at the next clock edge, provided event enable bit b of group g and group enable bit g are both 1 at that edge.
- R3: An evt_i pulse whose event enable or group enable is 0 leaves snp_pend unchanged and has no effect on irq_n.
- R4: irq_n is registered. It is 0 in the cycle after one in which any pending bit is covered by both of its enables, and 1 in the cycle after one in which none is.
- R5: rd_req with rd_grp = 0 is a full read. In the next cycle rd_valid is 1 and rd_pend holds all 24 pending bits as they were before the read, and all those bits are cleared.
- R6: rd_req with rd_grp = g+1 (1 packet, 2 chip, 3 modem) is a group read. rd_pend holds only group g's pending bits, the other fields read zero, and only group g is cleared.
- R7: Along with each read, rd_stat returns cond_i, sampled at the read edge, for the selected groups (zero elsewhere). This happens whatever the enables are.
- R8: Nothing on the snoop bus clears a pending bit or changes irq_n. Without a read, a pending bit never falls.
- R9: An enabled event arriving in the same cycle as a read that clears its group stays pending after the read, and it is not in that read's data.
- R10: An enable write (en_we) with en_sel = 0 loads the group enables from en_wdata[2:0]. With en_sel = g+1 it loads the event enables of group g. A write may come at any time. Clearing an enable drops the pin without clearing pending bits, and setting it again lowers the pin again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 24 | Event pulses, group g in bits 8g+7..8g |
| cond_i | input | 24 | Live condition of each source, same layout |
| en_we | input | 1 | Enable register write strobe |
| en_sel | input | 2 | 0 group enables, 1..3 event enables of group 0..2 |
| en_wdata | input | 8 | Enable write data |
| rd_req | input | 1 | Read and clear request |
| rd_grp | input | 2 | 0 all groups, 1..3 a single group |
| rd_valid | output | 1 | Read data valid, one cycle after rd_req |
| rd_pend | output | 24 | Pending bits returned by the read |
| rd_stat | output | 24 | Live condition returned by the read |
| snp_pend | output | 24 | Non-clearing view of the pending bits |
| irq_n | output | 1 | Active-low interrupt pin |

## Verification
The hardest case to reach from the ports is an enabled event that lands in exactly the cycle a read clears its group. It must survive the clear and must not appear in that read's data. The bench forces this case directly. The random phase also reaches it often, because it issues frequent reads against dense event traffic. A second hard case is a pending bit left stranded under a group enable that was turned off. The bench reaches it by writing the enables mid-stream, at random and in a directed sequence, and then watching the pin and the snoop bus.

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl #(
  parameter int GW = 8,
  parameter int NG = 3,
  localparam int TW = GW * NG,
  localparam int SW = $clog2(NG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] evt_i,
  input  logic [TW-1:0] cond_i,
  input  logic          en_we,
  input  logic [SW-1:0] en_sel,
  input  logic [GW-1:0] en_wdata,
  input  logic          rd_req,
  input  logic [SW-1:0] rd_grp,
  output logic          rd_valid,
  output logic [TW-1:0] rd_pend,
  output logic [TW-1:0] rd_stat,
  output logic [TW-1:0] snp_pend,
  output logic          irq_n
);

  logic [NG-1:0] grp_en;
  logic [TW-1:0] evt_en, pend_q, mask, clr;

  always_ff @(posedge clk)
    if (!rst_n) grp_en <= '0;
    else if (en_we && en_sel == '0) grp_en <= en_wdata[NG-1:0];

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign mask[g*GW +: GW] = evt_en[g*GW +: GW] & {GW{grp_en[g]}};
    assign clr[g*GW +: GW]  = {GW{rd_req && (rd_grp == '0 || rd_grp == SW'(g + 1))}};

    always_ff @(posedge clk)
      if (!rst_n) evt_en[g*GW +: GW] <= '0;
      else if (en_we && en_sel == SW'(g + 1)) evt_en[g*GW +: GW] <= en_wdata;
  end

  always_ff @(posedge clk)
    if (!rst_n) begin
      pend_q   <= '0;
      irq_n    <= 1'b1;
      rd_valid <= 1'b0;
      rd_pend  <= '0;
      rd_stat  <= '0;
    end else begin
      pend_q   <= (pend_q & ~clr) | (evt_i & mask);
      irq_n    <= ~|(pend_q & mask);
      rd_valid <= rd_req;
      if (rd_req) begin
        rd_pend <= pend_q & clr;
        rd_stat <= cond_i & clr;
      end
    end

  assign snp_pend = pend_q;

  p_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((snp_pend & $past(evt_i & mask)) == $past(evt_i & mask)));

  p_no_lost_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> ((snp_pend & $past(evt_i & mask)) == $past(evt_i & mask)));

  p_snoop_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> (($past(snp_pend) & ~snp_pend) == '0));

  p_read_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  p_group_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_grp == SW'(1)) |=> (rd_pend[TW-1:GW] == '0 && rd_stat[TW-1:GW] == '0));

  p_pin_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> ($past(snp_pend) != '0));

endmodule

// File: tb/sim_irq_group_ctrl.sv
module sim_irq_group_ctrl;
  localparam int TW = 24;

  logic clk = 0, rst_n = 0;
  logic [TW-1:0] evt_i = '0, cond_i = '0;
  logic en_we = 0, rd_req = 0;
  logic [1:0] en_sel = '0, rd_grp = '0;
  logic [7:0] en_wdata = '0;
  logic rd_valid, irq_n;
  logic [TW-1:0] rd_pend, rd_stat, snp_pend;

  int n_chk = 0, n_bad = 0;
  logic [TW-1:0] m_pend = '0, m_en = '0;
  logic [2:0] m_grp = '0;

  always #4 clk = ~clk;

  irq_group_ctrl u0 (.clk, .rst_n, .evt_i, .cond_i, .en_we, .en_sel, .en_wdata,
    .rd_req, .rd_grp, .rd_valid, .rd_pend, .rd_stat, .snp_pend, .irq_n);

  function automatic logic [TW-1:0] f_mask(logic [TW-1:0] en, logic [2:0] ge);
    return en & {{8{ge[2]}}, {8{ge[1]}}, {8{ge[0]}}};
  endfunction

  function automatic logic [TW-1:0] f_sel(logic [1:0] grp);
    case (grp)
      2'd0: return 24'hFFFFFF;
      2'd1: return 24'h0000FF;
      2'd2: return 24'h00FF00;
      default: return 24'hFF0000;
    endcase
  endfunction

  task automatic chk(string tag, logic [TW-1:0] act, logic [TW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // one cycle: drive, clock, update model, compare at posedge+1
  task automatic step(logic [TW-1:0] ev, logic [TW-1:0] cd, logic rq, logic [1:0] gs,
                      logic we, logic [1:0] es, logic [7:0] wd, string tag);
    logic [TW-1:0] mk, sl, e_pend, e_stat;
    logic e_irq;
    evt_i = ev; cond_i = cd; rd_req = rq; rd_grp = gs;
    en_we = we; en_sel = es; en_wdata = wd;
    mk = f_mask(m_en, m_grp);
    sl = rq ? f_sel(gs) : '0;
    e_pend = m_pend & sl;
    e_stat = cd & sl;
    e_irq = ~|(m_pend & mk);
    m_pend = (m_pend & ~sl) | (ev & mk);
    if (we) begin
      if (es == 0) m_grp = wd[2:0];
      else m_en[(es-1)*8 +: 8] = wd;
    end
    @(posedge clk); #1;
    chk({tag, " irq_n"}, TW'(irq_n), TW'(e_irq));
    chk({tag, " snp_pend"}, snp_pend, m_pend);
    chk({tag, " rd_valid"}, TW'(rd_valid), TW'(rq));
    if (rq) begin
      chk({tag, " rd_pend"}, rd_pend, e_pend);
      chk({tag, " rd_stat"}, rd_stat, e_stat);
    end
    evt_i = '0; rd_req = 0; en_we = 0;
  endtask

  task automatic idle(string tag);
    step('0, '0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=<%0d", cyc, 150000);
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    chk("R1 irq_n reset", TW'(irq_n), TW'(1));
    chk("R1 snp_pend reset", snp_pend, '0);
    chk("R1 rd_valid reset", TW'(rd_valid), '0);

    step(24'h000001, '0, 0, 0, 0, 0, 0, "R1 R3 all disabled after reset");
    idle("R3 no pin");

    step('0, '0, 0, 0, 1, 0, 8'h07, "R10 group enables");
    step('0, '0, 0, 0, 1, 1, 8'h0F, "R10 ev en g0");
    step('0, '0, 0, 0, 1, 2, 8'hF0, "R10 ev en g1");
    step('0, '0, 0, 0, 1, 3, 8'hFF, "R10 ev en g2");

    step(24'h0000F0, '0, 0, 0, 0, 0, 0, "R3 event enable clear");
    idle("R3 no pin after masked");
    step(24'h000003, '0, 0, 0, 0, 0, 0, "R2 latch g0");
    idle("R4 pin low");
    step('0, 24'hABCDEF, 0, 0, 0, 0, 0, "R8 snoop only");
    idle("R8 still pending");
    step('0, 24'h123456, 1, 0, 0, 0, 0, "R5 full read");
    idle("R4 pin released");

    step(24'h011000, '0, 0, 0, 0, 0, 0, "R2 latch g1 g2");
    step('0, 24'h5A5A5A, 1, 2, 0, 0, 0, "R6 R7 group read chip");
    idle("R6 modem kept");
    step(24'h020000, 24'h00FFFF, 1, 3, 0, 0, 0, "R9 event during clear");
    idle("R9 kept pending");

    step('0, '0, 0, 0, 1, 0, 8'h03, "R10 disable modem group");
    idle("R10 pin drops");
    idle("R10 pending held");
    step('0, '0, 0, 0, 1, 0, 8'h07, "R10 re-enable");
    idle("R10 pin again");
    step('0, 24'hFFFFFF, 1, 0, 0, 0, 0, "R5 R7 full read");
    idle("R5 empty");

    for (int i = 0; i < 4000; i++) begin
      logic [TW-1:0] ev;
      ev = $urandom() & $urandom() & $urandom();
      if ($urandom_range(0, 31) == 0)
        step(ev, $urandom(), ($urandom_range(0, 5) == 0), 2'($urandom_range(0, 3)),
             1, 2'($urandom_range(0, 3)), 8'($urandom()), "R10 random write");
      else
        step(ev, $urandom(), ($urandom_range(0, 5) == 0), 2'($urandom_range(0, 3)),
             0, 0, 0, "R2 R4 R6 R9 random");
    end
    summary();
  end
endmodule